// File: doc/BRIEF.md
# Interrupt-capable GPIO controller

A general-purpose I/O block for up to 32 pads, programmed through a 32-bit register bus with an APB-style setup/access handshake. Every pad can be driven from its own output and enable registers, or handed over as a whole to an alternate-function source through a per-pin bypass bit. Pad inputs are brought into the clock domain by a two-flop synchronizer. Software reads the synchronized values from a read-only register.

Each pin has an event detector. A level mode fires on high or low. An edge mode fires on rising or falling edges, or on both edges when its both-edges bit is set. Detected events collect in a pending register that has no acknowledge register: a bus read of the pending register returns its contents and empties it in the same access. The interrupt mask is never written directly. One register clears mask bits and another sets them, each acting only on the bits written as one. A single interrupt line is raised while any pending pin is not masked.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, all pins are inputs (direction register all ones) and every pin is masked (mask all ones). The bypass, output-enable, output-value, level-select, polarity, both-edges and pending registers are all zero. `irq` and `pad_oe` are low.
- R2: The register at byte offset 0x00 is the bypass, 0x04 direction, 0x08 output enable, 0x0C output value, 0x24 level select, 0x28 polarity and 0x2C both-edges. Each reads back what was written. Bits at or above `NPINS` read as zero in every register and ignore writes.
- R3: With the bypass bit at 0, `pad_out` follows the output-value bit. `pad_oe` equals the output-enable bit when the direction bit is 0, and is 0 when the direction bit is 1 (input).
- R4: With the bypass bit at 1, `pad_out` and `pad_oe` of that pin follow `alt_out` and `alt_oe`, whatever the GPIO registers hold.
- R5: The input register (0x10) returns `pad_in` through two flops. A change made between clock edges appears in a read sampled after the second rising edge, and not in one sampled after only the first.
- R6: The mask reads at 0x14, with 1 meaning masked. A write to 0x18 clears each mask bit written as 1. A write to 0x1C sets each mask bit written as 1. Bits written as 0 are unchanged.
- R7: A level-select bit of 1 makes the pin level-sensitive: active high when its polarity bit is 1, active low when 0.
- R8: A level-select bit of 0 makes the pin edge-sensitive: rising edges when polarity is 1, falling edges when 0. A both-edges bit of 1 catches both edges regardless of polarity.
- R9: Pending bits (0x20) stay set until read. A read returns them and clears them all. A level condition still present sets its bit again on the following cycle.
- R10: `irq` is high exactly when some pin is both pending and unmasked.
- R11: Writes to the pending register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pad_in | input | NPINS | Raw pad input levels |
| alt_out | input | NPINS | Alternate-function output values |
| alt_oe | input | NPINS | Alternate-function output enables |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the read-to-clear path. A design that clears without re-sampling would lose a persistent active-low level after the first read, and one that fails to clear would return the same pending bits twice. It checks the synchronizer latency by reading the input register one edge and then two edges after a pad change, so a missing or extra flop shows up as an early or late value. It writes zero bits to the mask registers and full 32-bit words to a 12-pin instance. A mask logic that toggles or stores written bits, or storage wider than the pin count, then shows in readback. Edge tests drive a pin of each edge kind together, so a polarity inversion or an ignored both-edges bit produces the wrong pending pattern.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the GPIO controller: register word indices.
// Assumes byte addressing with 32-bit words, so the index is paddr[5:2].
package gpio_irq_pkg;
    localparam int unsigned BUS_W = 32;

    typedef enum logic [3:0] {
        IDX_BYPASS  = 4'd0,
        IDX_DIR     = 4'd1,
        IDX_OEN     = 4'd2,
        IDX_OUT     = 4'd3,
        IDX_IN      = 4'd4,
        IDX_MASK    = 4'd5,
        IDX_UNMASK  = 4'd6,
        IDX_SETMASK = 4'd7,
        IDX_PEND    = 4'd8,
        IDX_LEVEL   = 4'd9,
        IDX_POL     = 4'd10,
        IDX_BOTH    = 4'd11
    } reg_idx_e;
endpackage

// File: rtl/gpio_sync2.sv
// Two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent (no multi-bit coherence needed).
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two sampling stages, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    assign q_out = sync_q;
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin event detector. Level mode: active high/low by polarity.
// Edge mode: rising/falling by polarity, both edges when both_en is set.
// Assumes s_in is already synchronized to clk.
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] level_sel,
    input  logic [W-1:0] polarity,
    input  logic [W-1:0] both_en,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    // Previous synchronized level, used for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= s_in;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall;
        assign rise = s_in[i] & ~prev_q[i];
        assign fall = ~s_in[i] & prev_q[i];
        // Select the event condition for this pin.
        always_comb begin
            if (level_sel[i])    hit[i] = polarity[i] ? s_in[i] : ~s_in[i];
            else if (both_en[i]) hit[i] = rise | fall;
            else                 hit[i] = polarity[i] ? rise : fall;
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
// Pad driver selection: GPIO registers or the alternate function, per pin.
// Assumes direction bit 1 means input, which forces the GPIO enable off.
module gpio_pad_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0] bypass,
    input  logic [W-1:0] dir_in,
    input  logic [W-1:0] gp_out,
    input  logic [W-1:0] gp_oe,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // Per-pin source select.
        always_comb begin
            if (bypass[i]) begin
                pad_out[i] = alt_out[i];
                pad_oe[i]  = alt_oe[i];
            end else begin
                pad_out[i] = gp_out[i];
                pad_oe[i]  = gp_oe[i] & ~dir_in[i];
            end
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// GPIO controller top: register file, bus decode, read-to-clear pending
// register, mask set/clear, and combined interrupt.
// Assumes NPINS in 1..32 and AW >= 7; reads complete in the access phase.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [BUS_W-1:0] pwdata,
    output logic [BUS_W-1:0] prdata,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] alt_out,
    input  logic [NPINS-1:0] alt_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             irq
);
    localparam int HI_W = AW - 6;

    logic [NPINS-1:0] byp_q, dir_q, oen_q, out_q, lvl_q, pol_q, both_q;
    logic [NPINS-1:0] mask_q, stat_q, sync_in, hit;
    logic [NPINS-1:0] wd;
    logic [3:0]       widx;
    logic             in_win, wr_en, rd_en, pend_clr;

    assign wd       = pwdata[NPINS-1:0];
    assign widx     = paddr[5:2];
    assign in_win   = (paddr[AW-1:6] == HI_W'(0));
    assign wr_en    = psel & penable & pwrite & in_win;
    assign rd_en    = psel & penable & ~pwrite & in_win;
    assign pend_clr = rd_en & (widx == IDX_PEND);

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pad_in), .q_out(sync_in)
    );

    gpio_irq_detect #(.W(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .s_in(sync_in), .level_sel(lvl_q),
        .polarity(pol_q), .both_en(both_q), .hit(hit)
    );

    gpio_pad_mux #(.W(NPINS)) u_mux (
        .bypass(byp_q), .dir_in(dir_q), .gp_out(out_q), .gp_oe(oen_q),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Configuration registers written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_q  <= '0;
            dir_q  <= '1;
            oen_q  <= '0;
            out_q  <= '0;
            lvl_q  <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (wr_en) begin
            case (widx)
                IDX_BYPASS: byp_q  <= wd;
                IDX_DIR:    dir_q  <= wd;
                IDX_OEN:    oen_q  <= wd;
                IDX_OUT:    out_q  <= wd;
                IDX_LEVEL:  lvl_q  <= wd;
                IDX_POL:    pol_q  <= wd;
                IDX_BOTH:   both_q <= wd;
                default: ;
            endcase
        end
    end

    // Mask: cleared by write-one to unmask, set by write-one to mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                                mask_q <= '1;
        else if (wr_en && widx == IDX_UNMASK)      mask_q <= mask_q & ~wd;
        else if (wr_en && widx == IDX_SETMASK)     mask_q <= mask_q | wd;
    end

    // Pending bits: sticky; a read replaces them with this cycle's events.
    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= '0;
        else if (pend_clr) stat_q <= hit;
        else               stat_q <= stat_q | hit;
    end

    // Read multiplexer, zero-extended above the pin count.
    always_comb begin
        prdata = '0;
        if (rd_en) begin
            case (widx)
                IDX_BYPASS: prdata[NPINS-1:0] = byp_q;
                IDX_DIR:    prdata[NPINS-1:0] = dir_q;
                IDX_OEN:    prdata[NPINS-1:0] = oen_q;
                IDX_OUT:    prdata[NPINS-1:0] = out_q;
                IDX_IN:     prdata[NPINS-1:0] = sync_in;
                IDX_MASK:   prdata[NPINS-1:0] = mask_q;
                IDX_PEND:   prdata[NPINS-1:0] = stat_q;
                IDX_LEVEL:  prdata[NPINS-1:0] = lvl_q;
                IDX_POL:    prdata[NPINS-1:0] = pol_q;
                IDX_BOTH:   prdata[NPINS-1:0] = both_q;
                default:    prdata = '0;
            endcase
        end
    end

    // Combined interrupt from unmasked pending bits.
    assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Property checker for gpio_irq_ctrl, attached by bind below.
module gpio_irq_ctrl_chk #(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [AW-1:0]    paddr,
    input logic [31:0]      pwdata,
    input logic             irq,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] byp_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] stat_q,
    input logic [NPINS-1:0] hit
);
    logic acc_unmask, acc_setmask, acc_pend_rd;
    assign acc_unmask  = psel && penable && pwrite  && paddr == AW'(8'h18);
    assign acc_setmask = psel && penable && pwrite  && paddr == AW'(8'h1C);
    assign acc_pend_rd = psel && penable && !pwrite && paddr == AW'(8'h20);

    p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_unmask |=> (mask_q & $past(pwdata[NPINS-1:0])) == '0);

    p_setmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_setmask |=> (mask_q & $past(pwdata[NPINS-1:0])) == $past(pwdata[NPINS-1:0]));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pend_rd |=> (stat_q & ~$past(hit)) == '0);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_pend_rd |=> ($past(stat_q) & ~stat_q) == '0);

    p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_q != '0);

    p_all_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);

    p_input_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q & ~byp_q) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .irq(irq), .pad_oe(pad_oe),
    .dir_q(dir_q), .byp_q(byp_q), .mask_q(mask_q), .stat_q(stat_q), .hit(hit)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
    localparam int NP = 12;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic [NP-1:0] pad_in = '0, alt_out = '0, alt_oe = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;
    int            total = 0, fails = 0;
    logic [31:0]   rd;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pad_in(pad_in), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bus tasks: start and end at a falling edge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        bus_rd(8'h04, rd); check("R1 dir", rd, 32'hFFF);
        bus_rd(8'h14, rd); check("R1 mask", rd, 32'hFFF);
        bus_rd(8'h20, rd); check("R1 pending", rd, 32'h0);
        bus_rd(8'h00, rd); check("R1 bypass", rd, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pad_oe", {20'b0, pad_oe}, 32'h0);
    endtask

    task automatic t_regs();
        bus_wr(8'h0C, 32'hFFFF_FFFF);
        bus_rd(8'h0C, rd); check("R2 out upper bits", rd, 32'hFFF);
        bus_wr(8'h08, 32'h0000_0A5A);
        bus_wr(8'h04, 32'h0000_00F0);
        bus_rd(8'h08, rd); check("R2 oe readback", rd, 32'hA5A);
        check("R3 pad_oe", {20'b0, pad_oe}, 32'hA0A);
        check("R3 pad_out", {20'b0, pad_out}, 32'hFFF);
    endtask

    task automatic t_bypass();
        alt_out = 12'h005; alt_oe = 12'h003;
        bus_wr(8'h00, 32'h0000_000F);
        check("R4 pad_out", {20'b0, pad_out}, 32'hFF5);
        check("R4 pad_oe", {20'b0, pad_oe}, 32'hA03);
    endtask

    task automatic t_input();
        pad_in = 12'h9C3;
        bus_rd(8'h10, rd); check("R5 one edge", rd, 32'h0);
        bus_rd(8'h10, rd); check("R5 two edges", rd, 32'h9C3);
    endtask

    task automatic t_mask();
        bus_wr(8'h18, 32'h0000_000F);
        bus_rd(8'h14, rd); check("R6 unmask", rd, 32'hFF0);
        bus_wr(8'h1C, 32'h0000_0003);
        bus_rd(8'h14, rd); check("R6 setmask", rd, 32'hFF3);
        bus_wr(8'h18, 32'h0);
        bus_wr(8'h1C, 32'h0);
        bus_rd(8'h14, rd); check("R6 zero writes", rd, 32'hFF3);
    endtask

    task automatic t_level();
        pad_in = 12'h000;
        idle(4);
        bus_wr(8'h24, 32'h003);
        bus_wr(8'h28, 32'h001);
        bus_rd(8'h20, rd);
        bus_rd(8'h20, rd); check("R9 level re-set after read", rd, 32'h002);
        check("R10 masked pending", {31'b0, irq}, 32'h0);
        bus_wr(8'h18, 32'h002);
        check("R10 unmasked pending", {31'b0, irq}, 32'h1);
        bus_wr(8'h1C, 32'h002);
        check("R10 remasked", {31'b0, irq}, 32'h0);
        pad_in = 12'h003;
        idle(4);
        bus_rd(8'h20, rd); check("R7 high and low", rd, 32'h003);
        bus_rd(8'h20, rd); check("R7 only high remains", rd, 32'h001);
        bus_wr(8'h24, 32'h000);
        bus_rd(8'h20, rd);
        bus_rd(8'h20, rd); check("R8 edge mode quiet", rd, 32'h0);
    endtask

    task automatic t_edge();
        bus_wr(8'h28, 32'h010);
        bus_wr(8'h2C, 32'hFFFF_F040);
        bus_rd(8'h2C, rd); check("R2 both-edges upper bits", rd, 32'h040);
        bus_rd(8'h20, rd);
        pad_in = 12'h073;
        idle(4);
        bus_rd(8'h20, rd); check("R8 rising", rd, 32'h050);
        pad_in = 12'h003;
        idle(4);
        bus_rd(8'h20, rd); check("R8 falling", rd, 32'h060);
    endtask

    task automatic t_pend_write();
        pad_in = 12'h043;
        idle(4);
        bus_wr(8'h20, 32'h0000_0FBF);
        bus_rd(8'h20, rd); check("R11 write ignored, set bit kept", rd, 32'h040);
        bus_wr(8'h20, 32'h0000_0FFF);
        bus_rd(8'h20, rd); check("R11 write sets nothing", rd, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_regs();
        t_bypass();
        t_input();
        t_mask();
        t_level();
        t_edge();
        t_pend_write();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #800000;
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule